// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A memory-mapped controller for one bank of general-purpose pins (32 by default). Software reaches it through a simple word-wide register bus with a select, a write strobe, a byte address and write data; reads return data combinationally in the cycle the select is high. Each pin has an output value and an output enable that drive the pad, and every input pin passes through a two-flop synchroniser before it is observed or used for interrupt detection.

Each pin can raise an interrupt on a level or on an edge. Three per-pin configuration bits choose the trigger: a level/edge select, a both-edges select and a polarity bit. Detected events latch into a status vector that software sees twice, raw and gated by a per-pin enable mask. Status bits are cleared by writing ones to a clear register, and the OR of all masked status bits is registered onto a single interrupt line for the system interrupt controller.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, pin_out and pin_oe are all zero (every pin is an input) and irq_o is low.
- R2: Byte offset 0x04 holds the output values and 0x08 the output enables (1 drives the pin); bit n of each drives pin_out[n] and pin_oe[n] from the cycle after the write, and both read back as written.
- R3: Offset 0x00 reads the input pins through a two-flop synchroniser: a pin change is invisible to a read one clock edge after it and visible two edges after it; writes to 0x00 have no effect.
- R4: With bit n of 0x0C at 0 (edge mode) and bit n of 0x10 at 0, bit n of 0x14 at 1 latches status on a rising edge of pin n and 0 latches it on a falling edge; a latched edge status stays set after the pin returns, until cleared. Status appears three clock edges after the pin change.
- R5: With bit n of 0x10 at 1 in edge mode, both rising and falling edges of pin n latch status, whatever bit n of 0x14 holds.
- R6: With bit n of 0x0C at 1 (level mode), status n is set in every cycle that pin n is at its active level (high when bit n of 0x14 is 1, low when 0); a clear while the pin is active has no visible effect, and status stays set after the pin leaves the active level until cleared.
- R7: Offset 0x18 is the interrupt enable mask (1 unmasks); offset 0x20 reads raw status ANDed with the mask while offset 0x1C reads raw status.
- R8: irq_o is the OR of all masked status bits, registered: it rises and falls one clock edge after the masked status does.
- R9: Writing offset 0x24 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged; a new event in the same cycle wins over the clear.
- R10: Changing the trigger configuration (0x0C, 0x10, 0x14) leaves existing status bits set.
- R11: Offsets above 0x24 read zero and ignore writes; writes to the read-only offsets 0x00, 0x1C and 0x20 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW (6) | Byte address; low two bits ignored |
| bus_wdata | input | NPIN (32) | Write data, bit n for pin n |
| bus_rdata | output | NPIN (32) | Read data, zero when not reading |
| pin_in | input | NPIN (32) | Asynchronous pin inputs |
| pin_out | output | NPIN (32) | Output values to the pads |
| pin_oe | output | NPIN (32) | Output enables to the pads |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench probes the synchroniser depth by reading the input and status registers one edge too early and then on time; a design with one flop too few or too many shows the new value in the wrong read. It clears a level-triggered pin while the level is still active, where a design that lets the clear beat the event would read the bit as zero, and writes zero bits to the clear register next to a set status, where a design treating the clear as plain write data would drop the bit. It also checks that a both-edges pin fires on the edge its polarity bit would reject, that a trigger reconfiguration keeps a pending status, and that irq_o lags the mask write by exactly one edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    // Word index (byte offset / 4) of each register; software decodes these.
    localparam int unsigned IDX_DIN  = 0;
    localparam int unsigned IDX_DOUT = 1;
    localparam int unsigned IDX_OE   = 2;
    localparam int unsigned IDX_LVL  = 3;
    localparam int unsigned IDX_DUAL = 4;
    localparam int unsigned IDX_POL  = 5;
    localparam int unsigned IDX_MASK = 6;
    localparam int unsigned IDX_RAW  = 7;
    localparam int unsigned IDX_MSKD = 8;
    localparam int unsigned IDX_CLR  = 9;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] dual_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] hit_o
);
    for (genvar n = 0; n < W; n++) begin : g_pin
        logic rise, fall, edge_hit, lvl_hit;
        always_comb begin
            rise     = cur_i[n] & ~prev_i[n];
            fall     = ~cur_i[n] & prev_i[n];
            // both-edges select overrides the polarity bit
            edge_hit = dual_i[n] ? (rise | fall) : (pol_i[n] ? rise : fall);
            lvl_hit  = pol_i[n] ? cur_i[n] : ~cur_i[n];
            hit_o[n] = lvl_i[n] ? lvl_hit : edge_hit;
        end
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPIN        = 32,
    parameter int AW          = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic            irq_o
);
    typedef struct packed {
        logic [NPIN-1:0] dout;
        logic [NPIN-1:0] oe;
        logic [NPIN-1:0] lvl;
        logic [NPIN-1:0] dual;
        logic [NPIN-1:0] pol;
        logic [NPIN-1:0] mask;
        logic [NPIN-1:0] stat;
        logic [NPIN-1:0] prev;
        logic            irq;
    } bank_st_t;

    bank_st_t        st_d, st_q;
    logic [NPIN-1:0] pin_sync;
    logic [NPIN-1:0] hit;
    logic [NPIN-1:0] clr_bits;
    logic [NPIN-1:0] stat_vec;
    logic [NPIN-1:0] mask_vec;
    int unsigned     widx;
    logic            unused_addr_lsb;

    assign widx            = 32'(bus_addr[AW-1:2]);
    assign unused_addr_lsb = ^bus_addr[1:0];

    gpio_in_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    gpio_trig_detect #(.W(NPIN)) u_detect (
        .cur_i  (pin_sync),
        .prev_i (st_q.prev),
        .lvl_i  (st_q.lvl),
        .dual_i (st_q.dual),
        .pol_i  (st_q.pol),
        .hit_o  (hit)
    );

    always_comb begin
        st_d     = st_q;
        clr_bits = '0;
        if (bus_sel && bus_we) begin
            case (widx)
                IDX_DOUT: st_d.dout = bus_wdata;
                IDX_OE:   st_d.oe   = bus_wdata;
                IDX_LVL:  st_d.lvl  = bus_wdata;
                IDX_DUAL: st_d.dual = bus_wdata;
                IDX_POL:  st_d.pol  = bus_wdata;
                IDX_MASK: st_d.mask = bus_wdata;
                IDX_CLR:  clr_bits  = bus_wdata;
                default:  ;
            endcase
        end
        st_d.prev = pin_sync;
        // a fresh event takes precedence over a clear in the same cycle
        st_d.stat = (st_q.stat & ~clr_bits) | hit;
        st_d.irq  = |(st_q.stat & st_q.mask);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (widx)
                IDX_DIN:  bus_rdata = pin_sync;
                IDX_DOUT: bus_rdata = st_q.dout;
                IDX_OE:   bus_rdata = st_q.oe;
                IDX_LVL:  bus_rdata = st_q.lvl;
                IDX_DUAL: bus_rdata = st_q.dual;
                IDX_POL:  bus_rdata = st_q.pol;
                IDX_MASK: bus_rdata = st_q.mask;
                IDX_RAW:  bus_rdata = st_q.stat;
                IDX_MSKD: bus_rdata = st_q.stat & st_q.mask;
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out  = st_q.dout;
    assign pin_oe   = st_q.oe;
    assign irq_o    = st_q.irq;
    assign stat_vec = st_q.stat;
    assign mask_vec = st_q.mask;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPIN = 32,
    parameter int AW   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_sel,
    input logic            bus_we,
    input logic [AW-1:0]   bus_addr,
    input logic [NPIN-1:0] bus_wdata,
    input logic [NPIN-1:0] bus_rdata,
    input logic [NPIN-1:0] pin_oe,
    input logic            irq_o,
    input logic [NPIN-1:0] stat_vec,
    input logic [NPIN-1:0] mask_vec
);
    int unsigned     cidx;
    logic            rd_cyc;
    logic [NPIN-1:0] clr_req;

    assign cidx    = 32'(bus_addr[AW-1:2]);
    assign rd_cyc  = bus_sel && !bus_we;
    assign clr_req = (bus_sel && bus_we && cidx == IDX_CLR) ? bus_wdata : '0;

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_vec & mask_vec)) |=> irq_o);

    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_vec & mask_vec)) |=> !irq_o);

    // R9 / R4: a set status bit only drops when a clear write names it
    p_stat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_vec) |=> (($past(stat_vec & ~clr_req) & ~stat_vec) == '0));

    p_oe_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && cidx == IDX_OE) |-> (bus_rdata == pin_oe));

    p_masked_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && cidx == IDX_MSKD) |-> ((bus_rdata & ~mask_vec) == '0));

    p_undef_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && cidx > IDX_CLR) |-> (bus_rdata == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq_o     (irq_o),
    .stat_vec  (stat_vec),
    .mask_vec  (mask_vec)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
    localparam int NPIN = 32;
    localparam int AW   = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [NPIN-1:0] bus_wdata = '0;
    logic [NPIN-1:0] bus_rdata;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] pin_out;
    logic [NPIN-1:0] pin_oe;
    logic            irq_o;

    int checks = 0;
    int errors = 0;
    logic [NPIN-1:0] exp_q[$];
    string           tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    gpio_irq_bank #(.NPIN(NPIN), .AW(AW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    // monitor: pops the expected value queued by the driver for each read
    always @(negedge clk) begin
        if (bus_sel && !bus_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL monitor: read with no expectation, got %h", bus_rdata);
            end else begin
                logic [NPIN-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: addr %h got %h expected %h", t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [NPIN-1:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [NPIN-1:0] e, input string t);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic set_pins(input logic [NPIN-1:0] v);
        @(posedge clk); #1;
        pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk_port(input string t, input logic [NPIN-1:0] got, input logic [NPIN-1:0] e);
        checks++;
        if (got !== e) begin
            errors++;
            $display("FAIL %s: got %h expected %h", t, got, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk_port("R1 pin_oe", pin_oe, '0);
        chk_port("R1 pin_out", pin_out, '0);
        chk_port("R1 irq_o", {31'd0, irq_o}, '0);
        for (int i = 1; i <= 8; i++) rd(AW'(i * 4), '0, "R1 register reset");

        // R2 output data and enable
        wr(6'h04, 32'hA5A5_0F0F);
        wr(6'h08, 32'hFFFF_0000);
        @(negedge clk);
        chk_port("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        chk_port("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        rd(6'h04, 32'hA5A5_0F0F, "R2 dout readback");
        rd(6'h08, 32'hFFFF_0000, "R2 oe readback");

        // R3 synchroniser latency on data-in
        set_pins(32'h1234_5600);
        rd(6'h00, 32'h0, "R3 one edge too early");
        rd(6'h00, 32'h1234_5600, "R3 after two edges");

        // R4 default falling-edge detection and status latency
        set_pins(32'h0);
        idle(1);
        rd(6'h1C, 32'h0, "R4 status two edges after change");
        rd(6'h1C, 32'h1234_5600, "R4 falling edges latched");

        // R9 partial clear, then full clear
        wr(6'h24, 32'h0034_5600);
        rd(6'h1C, 32'h1200_0000, "R9 partial clear");
        wr(6'h24, 32'hFFFF_FFFF);
        rd(6'h1C, 32'h0, "R9 full clear");

        // R4 rising edge on pin 0 and hold
        wr(6'h14, 32'h1);
        set_pins(32'h1);
        idle(2);
        rd(6'h1C, 32'h1, "R4 rising edge");
        set_pins(32'h0);
        idle(2);
        rd(6'h1C, 32'h1, "R4 edge status held, fall ignored");
        wr(6'h24, 32'hFFFF_FFFE);
        rd(6'h1C, 32'h1, "R9 zero bit leaves status");
        wr(6'h24, 32'h1);
        rd(6'h1C, 32'h0, "R9 clear pin 0");

        // R5 both edges on pin 2 with polarity 0
        wr(6'h10, 32'h4);
        set_pins(32'h4);
        idle(2);
        rd(6'h1C, 32'h4, "R5 rising edge with dual set");
        wr(6'h24, 32'h4);
        rd(6'h1C, 32'h0, "R5 cleared");
        set_pins(32'h0);
        idle(2);
        rd(6'h1C, 32'h4, "R5 falling edge with dual set");
        wr(6'h24, 32'h4);

        // R6 active-high level on pin 3
        wr(6'h0C, 32'h8);
        wr(6'h14, 32'h9);
        set_pins(32'h8);
        idle(2);
        rd(6'h1C, 32'h8, "R6 level high status");
        wr(6'h24, 32'h8);
        rd(6'h1C, 32'h8, "R6 clear while active");
        set_pins(32'h0);
        idle(2);
        rd(6'h1C, 32'h8, "R6 status latched after level leaves");

        // R10 reconfiguration keeps status
        wr(6'h0C, 32'h0);
        rd(6'h1C, 32'h8, "R10 type change keeps status");
        wr(6'h24, 32'hFFFF_FFFF);
        rd(6'h1C, 32'h0, "R10 cleared afterwards");

        // R6 active-low level on pin 4 (pin already low)
        wr(6'h0C, 32'h10);
        rd(6'h1C, 32'h10, "R6 level low status");
        set_pins(32'h10);
        idle(2);
        wr(6'h24, 32'h10);
        rd(6'h1C, 32'h0, "R6 cleared once inactive");

        // R7 / R8 mask, masked status and interrupt timing
        set_pins(32'h11);
        idle(2);
        rd(6'h1C, 32'h1, "R7 raw status");
        rd(6'h20, 32'h0, "R7 masked status with mask clear");
        @(negedge clk);
        chk_port("R8 irq low while masked", {31'd0, irq_o}, '0);
        wr(6'h18, 32'h1);
        @(negedge clk);
        chk_port("R8 irq lags mask by one edge", {31'd0, irq_o}, '0);
        @(negedge clk);
        chk_port("R8 irq asserted", {31'd0, irq_o}, 32'h1);
        rd(6'h20, 32'h1, "R7 masked status");
        rd(6'h18, 32'h1, "R7 mask readback");
        wr(6'h24, 32'h1);
        @(negedge clk);
        chk_port("R8 irq still high one edge after clear", {31'd0, irq_o}, 32'h1);
        @(negedge clk);
        chk_port("R8 irq deasserted", {31'd0, irq_o}, '0);
        rd(6'h20, 32'h0, "R7 masked status cleared");

        // R11 undefined and read-only offsets
        wr(6'h28, 32'hFFFF_FFFF);
        rd(6'h28, 32'h0, "R11 undefined offset reads zero");
        rd(6'h3C, 32'h0, "R11 top offset reads zero");
        wr(6'h1C, 32'hFFFF_FFFF);
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h1C, 32'h0, "R11 status unaffected");
        rd(6'h00, 32'h11, "R11 data-in unaffected");
        rd(6'h04, 32'hA5A5_0F0F, "R11 dout unaffected");
        @(negedge clk);
        chk_port("R11 pin_oe unaffected", pin_oe, 32'hFFFF_0000);

        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule